// File: doc/BRIEF.md
# Space Vector Sector and Dwell Calculator

This block turns a two-axis stationary-frame voltage reference into the data a three-phase space vector modulator needs for one switching period. Each accepted sample is a signed fixed-point pair (alpha, beta) qualified by a one-cycle strobe. The block finds the 60-degree sector that holds the vector and names the two adjacent active switching states. It then works out the normalized time share for each of those two states and for the all-low zero state. No arctangent is used. Three projections of the vector are reduced to sign bits, and every dwell term is a sum of two products by fixed constants.

A full-scale value of 1.0 is `2^FRAC` in both the inputs and the dwell outputs. If the two active shares add up to more than one period, they are scaled down proportionally by a pipelined restoring divider, and the zero share becomes 0. The block takes a new sample on every clock cycle and returns each result a fixed number of cycles later. The results after the division stay in order with the samples.

Top module: `sv_dwell_calc`

## Requirements
- R1: From U1 = beta, U2 = 0.8660·alpha − 0.5·beta and U3 = −0.8660·alpha − 0.5·beta, the flags A, B and C are 1 when U1, U2 and U3 are strictly positive. The projections are evaluated exactly in integers, using 56755/65536 for 0.8660 and 32768/65536 for 0.5. With code N = 4C + 2B + A, the output `sector` (binary 1..6) is 1, 2, 3, 4, 5, 6 for N = 3, 1, 5, 4, 6, 2.
- R2: A switching state is 3 bits: bit 2 is phase U, bit 0 is phase W, and 1 means high side. The pair (`vec_first`, `vec_second`) is (4,6), (2,6), (2,3), (1,3), (1,5), (4,5) for sectors 1 to 6. The two codes always differ in exactly one bit.
- R3: The raw shares are floor((ka·alpha + kb·beta)/65536), with negative results forced to 0. Write p = 65536, r = 37837 and w = 75674. The first share uses (ka, kb) = (p,−r), (−p,r), (0,w), (0,−w), (−p,−r), (p,r) for sectors 1 to 6. The second share uses (0,w), (p,r), (−p,−r), (−p,r), (p,−r), (0,−w).
- R4: When the raw shares add up to at most ONE = 2^FRAC, `dwell_t1` and `dwell_t2` are the raw shares and `dwell_t0` = ONE − t1 − t2.
- R5: When the raw shares add up to S > ONE, `dwell_t1` = floor((2·t1·ONE + S)/(2·S)), `dwell_t2` = ONE − `dwell_t1`, and `dwell_t0` = 0.
- R6: A zero input (N of 0 or 7) gives sector 1 with codes (4,6), `dwell_t1` = `dwell_t2` = 0 and `dwell_t0` = ONE.
- R7: `out_valid` rises exactly LAT cycles after each accepted `in_valid`. LAT = FRAC+3 when PIPE_DIV = 1 and 2 when PIPE_DIV = 0. A sample may arrive on every cycle.
- R8: While `rst_n` is low, `out_valid`, `sector`, both codes and all dwell outputs are 0.
- R9: The result outputs change only on a cycle where `out_valid` is 1. Input changes while `in_valid` is 0 have no effect on them.
- R10: On every result, `dwell_t0` + `dwell_t1` + `dwell_t2` = ONE, and each share is at most ONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for alpha/beta |
| alpha | input | IN_W | Signed alpha component, 1.0 = 2^FRAC |
| beta | input | IN_W | Signed beta component, 1.0 = 2^FRAC |
| out_valid | output | 1 | Result strobe |
| sector | output | 3 | Sector number 1..6 |
| vec_first | output | 3 | First active switching state |
| vec_second | output | 3 | Second active switching state |
| dwell_t1 | output | FRAC+1 | Share of the first active state |
| dwell_t2 | output | FRAC+1 | Share of the second active state |
| dwell_t0 | output | FRAC+1 | Share of the zero state |

## Verification
The bench builds the block with IN_W = 12, FRAC = 10 and the registered divider, which gives LAT = 13. With these values ONE is 1024 and the inputs reach almost ±2.0. A coarse grid over the full input square therefore covers every sector, both exact axes, the zero vector and many overmodulated points where the divider and its rounding decide the result. Back-to-back samples fill all thirteen stages at once, so any stage that mixes up results from neighbouring samples is caught.

// File: rtl/svdw_pkg.sv
package svdw_pkg;

   localparam int COEF_FRAC     = 16;
   localparam int COEF_W        = COEF_FRAC + 3;
   localparam int C_UNIT        = 65536;
   localparam int C_HALF        = 32768;
   localparam int C_RT3_HALF    = 56755;
   localparam int C_INV_RT3     = 37837;
   localparam int C_TWO_INV_RT3 = 75674;

   typedef logic [2:0] swcode_t;
   typedef logic [2:0] sector_t;

   function automatic swcode_t lead_state(input sector_t sec);
      case (sec)
         3'd1:    return 3'd4;
         3'd2:    return 3'd2;
         3'd3:    return 3'd2;
         3'd4:    return 3'd1;
         3'd5:    return 3'd1;
         3'd6:    return 3'd4;
         default: return 3'd4;
      endcase
   endfunction

   function automatic swcode_t trail_state(input sector_t sec);
      case (sec)
         3'd1:    return 3'd6;
         3'd2:    return 3'd6;
         3'd3:    return 3'd3;
         3'd4:    return 3'd3;
         3'd5:    return 3'd5;
         3'd6:    return 3'd5;
         default: return 3'd6;
      endcase
   endfunction

   // Coefficient on alpha (on_beta=0) or beta (on_beta=1) for the lead
   // (second=0) or trail (second=1) share, in units of 2^-COEF_FRAC.
   function automatic logic signed [COEF_W-1:0] share_coef(input sector_t sec,
                                                           input logic second,
                                                           input logic on_beta);
      logic signed [COEF_W-1:0] p, r, w, z;
      logic signed [COEF_W-1:0] a1, b1, a2, b2;
      p = COEF_W'(C_UNIT);
      r = COEF_W'(C_INV_RT3);
      w = COEF_W'(C_TWO_INV_RT3);
      z = '0;
      case (sec)
         3'd2:    begin a1 = -p; b1 =  r; a2 =  p; b2 =  r; end
         3'd3:    begin a1 =  z; b1 =  w; a2 = -p; b2 = -r; end
         3'd4:    begin a1 =  z; b1 = -w; a2 = -p; b2 =  r; end
         3'd5:    begin a1 = -p; b1 = -r; a2 =  p; b2 = -r; end
         3'd6:    begin a1 =  p; b1 =  r; a2 =  z; b2 = -w; end
         default: begin a1 =  p; b1 = -r; a2 =  z; b2 =  w; end
      endcase
      case ({second, on_beta})
         2'b00:   return a1;
         2'b01:   return b1;
         2'b10:   return a2;
         default: return b2;
      endcase
   endfunction

endpackage

// File: rtl/svdw_sector_decode.sv
module svdw_sector_decode
   import svdw_pkg::*;
#(
   parameter int IN_W = 16
) (
   input  logic signed [IN_W-1:0] alpha,
   input  logic signed [IN_W-1:0] beta,
   output sector_t                sector,
   output logic                   degenerate,
   output swcode_t                lead,
   output swcode_t                trail
);

   localparam int PW = IN_W + COEF_W + 1;
   localparam logic signed [PW-1:0] K_RT3  = PW'(C_RT3_HALF);
   localparam logic signed [PW-1:0] K_HALF = PW'(C_HALF);

   logic signed [PW-1:0] ax, bh, u2, u3;
   logic                 fa, fb, fc;
   logic [2:0]           code_n;

   always_comb begin
      ax = PW'(alpha) * K_RT3;
      bh = PW'(beta) * K_HALF;
      u2 = ax - bh;
      u3 = -ax - bh;
      fa = !beta[IN_W-1] && (beta != '0);
      fb = !u2[PW-1] && (u2 != '0);
      fc = !u3[PW-1] && (u3 != '0);
      code_n = {fc, fb, fa};
      degenerate = 1'b0;
      case (code_n)
         3'd3:    sector = 3'd1;
         3'd1:    sector = 3'd2;
         3'd5:    sector = 3'd3;
         3'd4:    sector = 3'd4;
         3'd6:    sector = 3'd5;
         3'd2:    sector = 3'd6;
         default: begin
            sector     = 3'd1;
            degenerate = 1'b1;
         end
      endcase
      lead  = lead_state(sector);
      trail = trail_state(sector);
   end

endmodule

// File: rtl/svdw_share_calc.sv
module svdw_share_calc
   import svdw_pkg::*;
#(
   parameter int IN_W = 16,
   parameter int TW   = 17
) (
   input  logic signed [IN_W-1:0] alpha,
   input  logic signed [IN_W-1:0] beta,
   input  sector_t                sector,
   input  logic                   degenerate,
   output logic [TW-1:0]          t_lead,
   output logic [TW-1:0]          t_trail
);

   localparam int PW = IN_W + COEF_W + 2;
   localparam logic signed [PW-1:0] T_MAX = PW'((64'd1 << TW) - 64'd1);

   for (genvar j = 0; j < 2; j++) begin : g_term
      logic signed [COEF_W-1:0] ka, kb;
      logic signed [PW-1:0]     acc, shf;
      logic [TW-1:0]            t_val;

      always_comb begin
         ka  = share_coef(sector, 1'(j), 1'b0);
         kb  = share_coef(sector, 1'(j), 1'b1);
         acc = PW'(alpha) * PW'(ka) + PW'(beta) * PW'(kb);
         shf = acc >>> COEF_FRAC;
         if (degenerate || shf[PW-1])
            t_val = '0;
         else if (shf > T_MAX)
            t_val = '1;
         else
            t_val = shf[TW-1:0];
      end
   end

   assign t_lead  = g_term[0].t_val;
   assign t_trail = g_term[1].t_val;

endmodule

// File: rtl/svdw_div_step.sv
module svdw_div_step #(
   parameter int SW      = 18,
   parameter int QW      = 15,
   parameter int BIT_POS = 14,
   parameter bit FIRST   = 1'b0
) (
   input  logic [SW:0]   rem_i,
   input  logic [QW-1:0] q_i,
   input  logic [SW-1:0] sum_i,
   output logic [SW:0]   rem_o,
   output logic [QW-1:0] q_o
);

   logic [SW:0] remd;
   logic        ge;

   if (FIRST) begin : g_first
      assign remd = rem_i;
   end else begin : g_next
      assign remd = rem_i << 1;
   end

   always_comb begin
      ge    = remd >= {1'b0, sum_i};
      rem_o = ge ? (remd - {1'b0, sum_i}) : remd;
      q_o   = q_i;
      q_o[BIT_POS] = ge;
   end

endmodule

// File: rtl/sv_dwell_calc.sv
module sv_dwell_calc
   import svdw_pkg::*;
#(
   parameter int IN_W     = 16,
   parameter int FRAC     = 14,
   parameter bit PIPE_DIV = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] alpha,
   input  logic signed [IN_W-1:0] beta,
   output logic                   out_valid,
   output logic [2:0]             sector,
   output logic [2:0]             vec_first,
   output logic [2:0]             vec_second,
   output logic [FRAC:0]          dwell_t1,
   output logic [FRAC:0]          dwell_t2,
   output logic [FRAC:0]          dwell_t0
);

   localparam int TW   = IN_W + 1;
   localparam int SW   = TW + 1;
   localparam int QW   = FRAC + 1;
   localparam int DW   = FRAC + 1;
   localparam int NSTG = FRAC + 1;
   localparam logic [SW-1:0] ONE_S = SW'(64'd1 << FRAC);
   localparam logic [DW-1:0] ONE_D = DW'(64'd1 << FRAC);

   if (FRAC < 2 || FRAC > IN_W - 2) begin : g_bad_cfg
      $error("sv_dwell_calc: FRAC must lie in 2..IN_W-2");
   end

   typedef struct packed {
      logic          vld;
      sector_t       sec;
      swcode_t       va;
      swcode_t       vb;
      logic [TW-1:0] t1;
      logic [TW-1:0] t2;
      logic [SW-1:0] sum;
      logic          ovf;
      logic [SW:0]   rem;
      logic [QW-1:0] q;
   } slot_t;

   sector_t       dec_sec;
   logic          dec_deg;
   swcode_t       dec_va, dec_vb;
   logic [TW-1:0] raw_t1, raw_t2;
   logic [SW-1:0] raw_sum;

   svdw_sector_decode #(.IN_W(IN_W)) u_decode (
      .alpha      (alpha),
      .beta       (beta),
      .sector     (dec_sec),
      .degenerate (dec_deg),
      .lead       (dec_va),
      .trail      (dec_vb)
   );

   svdw_share_calc #(.IN_W(IN_W), .TW(TW)) u_share (
      .alpha      (alpha),
      .beta       (beta),
      .sector     (dec_sec),
      .degenerate (dec_deg),
      .t_lead     (raw_t1),
      .t_trail    (raw_t2)
   );

   assign raw_sum = {1'b0, raw_t1} + {1'b0, raw_t2};

   slot_t s0_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s0_q <= '0;
      end else begin
         s0_q.vld <= in_valid;
         if (in_valid) begin
            s0_q.sec <= dec_sec;
            s0_q.va  <= dec_va;
            s0_q.vb  <= dec_vb;
            s0_q.t1  <= raw_t1;
            s0_q.t2  <= raw_t2;
            s0_q.sum <= raw_sum;
            s0_q.ovf <= raw_sum > ONE_S;
            s0_q.rem <= (SW+1)'(raw_t1);
            s0_q.q   <= '0;
         end
      end
   end

   // Proportional rescale: one quotient bit per step, MSB (weight 1.0) first.
   for (genvar k = 0; k < NSTG; k++) begin : g_stg
      slot_t src, nxt, stg_q;

      if (k == 0) begin : g_src0
         assign src = s0_q;
      end else begin : g_srck
         assign src = g_stg[k-1].stg_q;
      end

      svdw_div_step #(
         .SW      (SW),
         .QW      (QW),
         .BIT_POS (QW - 1 - k),
         .FIRST   (k == 0)
      ) u_step (
         .rem_i (src.rem),
         .q_i   (src.q),
         .sum_i (src.sum),
         .rem_o (nxt.rem),
         .q_o   (nxt.q)
      );

      assign nxt.vld = src.vld;
      assign nxt.sec = src.sec;
      assign nxt.va  = src.va;
      assign nxt.vb  = src.vb;
      assign nxt.t1  = src.t1;
      assign nxt.t2  = src.t2;
      assign nxt.sum = src.sum;
      assign nxt.ovf = src.ovf;

      if (PIPE_DIV) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= nxt;
         end
      end else begin : g_wire
         assign stg_q = nxt;
      end
   end

   slot_t         fin;
   logic          rnd_up;
   logic [DW-1:0] q_rnd;

   assign fin    = g_stg[NSTG-1].stg_q;
   assign rnd_up = {fin.rem, 1'b0} >= {2'b00, fin.sum};
   assign q_rnd  = DW'(fin.q) + DW'(rnd_up);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         sector     <= '0;
         vec_first  <= '0;
         vec_second <= '0;
         dwell_t1   <= '0;
         dwell_t2   <= '0;
         dwell_t0   <= '0;
      end else begin
         out_valid <= fin.vld;
         if (fin.vld) begin
            sector     <= fin.sec;
            vec_first  <= fin.va;
            vec_second <= fin.vb;
            if (fin.ovf) begin
               dwell_t1 <= q_rnd;
               dwell_t2 <= ONE_D - q_rnd;
               dwell_t0 <= '0;
            end else begin
               dwell_t1 <= DW'(fin.t1);
               dwell_t2 <= DW'(fin.t2);
               dwell_t0 <= DW'(ONE_S - fin.sum);
            end
         end
      end
   end

endmodule

// File: rtl/sv_dwell_calc_chk.sv
module sv_dwell_calc_chk #(
   parameter int IN_W     = 16,
   parameter int FRAC     = 14,
   parameter bit PIPE_DIV = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          out_valid,
   input logic [2:0]    sector,
   input logic [2:0]    vec_first,
   input logic [2:0]    vec_second,
   input logic [FRAC:0] dwell_t1,
   input logic [FRAC:0] dwell_t2,
   input logic [FRAC:0] dwell_t0
);

   localparam int LAT = PIPE_DIV ? FRAC + 3 : 2;
   localparam int XW  = FRAC + 3;
   localparam logic [XW-1:0] ONE_X = XW'(64'd1 << FRAC);
   localparam int UNUSED_W = IN_W;

   logic [LAT-1:0] vshift;

   always_ff @(posedge clk) begin
      if (!rst_n) vshift <= '0;
      else        vshift <= {vshift[LAT-2:0], in_valid};
   end

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vshift[LAT-1]);

   p_sector_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sector >= 3'd1 && sector <= 3'd6));

   p_adjacent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(vec_first ^ vec_second) == 1));

   p_sum_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (XW'(dwell_t0) + XW'(dwell_t1) + XW'(dwell_t2) == ONE_X));

   p_share_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (XW'(dwell_t1) <= ONE_X && XW'(dwell_t2) <= ONE_X));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(sector) && $stable(vec_first) && $stable(vec_second)
                      && $stable(dwell_t1) && $stable(dwell_t2) && $stable(dwell_t0)));

   initial begin : p_width_note
      if (UNUSED_W < 4) $display("sv_dwell_calc_chk: narrow input");
   end

endmodule

bind sv_dwell_calc sv_dwell_calc_chk #(
   .IN_W     (IN_W),
   .FRAC     (FRAC),
   .PIPE_DIV (PIPE_DIV)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .sector     (sector),
   .vec_first  (vec_first),
   .vec_second (vec_second),
   .dwell_t1   (dwell_t1),
   .dwell_t2   (dwell_t2),
   .dwell_t0   (dwell_t0)
);

// File: tb/sv_dwell_calc_tb.sv
module sv_dwell_calc_tb;

   localparam int  IN_W = 12;
   localparam int  FRAC = 10;
   localparam int  LAT  = FRAC + 3;
   localparam longint ONE = 64'd1 << FRAC;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   in_valid = 1'b0;
   logic signed [IN_W-1:0] alpha = '0;
   logic signed [IN_W-1:0] beta = '0;
   logic                   out_valid;
   logic [2:0]             sector, vec_first, vec_second;
   logic [FRAC:0]          dwell_t1, dwell_t2, dwell_t0;

   sv_dwell_calc #(.IN_W(IN_W), .FRAC(FRAC), .PIPE_DIV(1'b1)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .alpha      (alpha),
      .beta       (beta),
      .out_valid  (out_valid),
      .sector     (sector),
      .vec_first  (vec_first),
      .vec_second (vec_second),
      .dwell_t1   (dwell_t1),
      .dwell_t2   (dwell_t2),
      .dwell_t0   (dwell_t0)
   );

   always #4 clk = ~clk;

   typedef struct {
      int     sec;
      int     va;
      int     vb;
      longint t1;
      longint t2;
      longint t0;
      int     kind;   // 0 normal, 1 rescaled, 2 zero input
      longint due;
   } exp_t;

   exp_t   sb[$];
   int     n_tests = 0;
   int     n_fail = 0;
   longint cyc = 0;
   bit     finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic exp_t model(input int a, input int b);
      exp_t   e;
      bit     fa, fb, fc;
      int     n;
      longint ka1, kb1, ka2, kb2, r1, r2, s;
      fa = b > 0;
      fb = (longint'(56755) * a - longint'(32768) * b) > 0;
      fc = (-longint'(56755) * a - longint'(32768) * b) > 0;
      n = 4 * fc + 2 * fb + fa;
      e.kind = 0;
      case (n)
         3: e.sec = 1;
         1: e.sec = 2;
         5: e.sec = 3;
         4: e.sec = 4;
         6: e.sec = 5;
         2: e.sec = 6;
         default: begin e.sec = 1; e.kind = 2; end
      endcase
      case (e.sec)
         1: begin e.va = 4; e.vb = 6; ka1 =  65536; kb1 = -37837; ka2 =      0; kb2 =  75674; end
         2: begin e.va = 2; e.vb = 6; ka1 = -65536; kb1 =  37837; ka2 =  65536; kb2 =  37837; end
         3: begin e.va = 2; e.vb = 3; ka1 =      0; kb1 =  75674; ka2 = -65536; kb2 = -37837; end
         4: begin e.va = 1; e.vb = 3; ka1 =      0; kb1 = -75674; ka2 = -65536; kb2 =  37837; end
         5: begin e.va = 1; e.vb = 5; ka1 = -65536; kb1 = -37837; ka2 =  65536; kb2 = -37837; end
         default: begin e.va = 4; e.vb = 5; ka1 = 65536; kb1 = 37837; ka2 = 0; kb2 = -75674; end
      endcase
      r1 = (ka1 * a + kb1 * b) >>> 16;
      r2 = (ka2 * a + kb2 * b) >>> 16;
      if (r1 < 0) r1 = 0;
      if (r2 < 0) r2 = 0;
      if (e.kind == 2) begin r1 = 0; r2 = 0; end
      s = r1 + r2;
      if (s > ONE) begin
         e.kind = 1;
         e.t1 = (2 * r1 * ONE + s) / (2 * s);
         e.t2 = ONE - e.t1;
         e.t0 = 0;
      end else begin
         e.t1 = r1;
         e.t2 = r2;
         e.t0 = ONE - s;
      end
      return e;
   endfunction

   task automatic drive(input int a, input int b);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      alpha    = IN_W'(a);
      beta     = IN_W'(b);
      e = model(a, b);
      e.due = cyc + LAT;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected out_valid", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(cyc == e.due, "R7 latency", cyc, e.due);
            check(sector == 3'(e.sec), "R1 sector", sector, e.sec);
            check(vec_first == 3'(e.va) && vec_second == 3'(e.vb), "R2 state pair",
                  {vec_first, vec_second}, {3'(e.va), 3'(e.vb)});
            check(longint'(dwell_t0) + dwell_t1 + dwell_t2 == ONE, "R10 share sum",
                  longint'(dwell_t0) + dwell_t1 + dwell_t2, ONE);
            case (e.kind)
               2: begin
                  check(dwell_t1 == 0 && dwell_t2 == 0, "R6 zero-input shares",
                        dwell_t1 + dwell_t2, 0);
                  check(dwell_t0 == ONE, "R6 zero-input t0", dwell_t0, ONE);
               end
               1: begin
                  check(dwell_t1 == e.t1, "R5 rescaled t1", dwell_t1, e.t1);
                  check(dwell_t2 == e.t2 && dwell_t0 == 0, "R5 rescaled t2/t0",
                        dwell_t2, e.t2);
               end
               default: begin
                  check(dwell_t1 == e.t1, "R3 share t1", dwell_t1, e.t1);
                  check(dwell_t2 == e.t2, "R3 share t2", dwell_t2, e.t2);
                  check(dwell_t0 == e.t0, "R4 zero share", dwell_t0, e.t0);
               end
            endcase
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [2:0]    h_sec, h_va, h_vb;
      logic [FRAC:0] h_t0, h_t1, h_t2;

      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && sector == 0 && vec_first == 0 && vec_second == 0,
            "R8 reset control", {out_valid, sector}, 0);
      check(dwell_t0 == 0 && dwell_t1 == 0 && dwell_t2 == 0, "R8 reset shares",
            dwell_t0 + dwell_t1 + dwell_t2, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // Directed points: one per sector, axes, zero and overmodulation corners
      drive(800, 300);
      drive(100, 700);
      drive(-600, 400);
      drive(-600, -300);
      drive(-100, -700);
      drive(500, -500);
      drive(0, 0);
      drive(1000, 0);
      drive(-500, 0);
      drive(0, 800);
      drive(0, -800);
      drive(1800, 1500);
      drive(-2048, -2048);
      drive(2047, 2047);
      drive(2047, 0);
      idle(LAT + 4);

      // Full grid, back to back
      for (int i = -2048; i < 2048; i += 256) begin
         for (int j = -2048; j < 2048; j += 256) begin
            drive(i, j);
         end
      end
      idle(2);

      // Sparse stream with gaps
      for (int k = 0; k < 12; k++) begin
         drive(150 * k - 900, 1100 - 170 * k);
         idle(k % 3);
      end
      idle(LAT + 4);
      check(sb.size() == 0, "R7 all results returned", sb.size(), 0);

      // R9: input changes without strobe leave results untouched
      h_sec = sector; h_va = vec_first; h_vb = vec_second;
      h_t0 = dwell_t0; h_t1 = dwell_t1; h_t2 = dwell_t2;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         alpha = IN_W'(37 * k - 400);
         beta  = IN_W'(500 - 61 * k);
      end
      idle(LAT + 2);
      check(sector == h_sec && vec_first == h_va && vec_second == h_vb,
            "R9 held sector/states", {sector, vec_first, vec_second}, {h_sec, h_va, h_vb});
      check(dwell_t0 == h_t0 && dwell_t1 == h_t1 && dwell_t2 == h_t2,
            "R9 held shares", {dwell_t0, dwell_t1, dwell_t2}, {h_t0, h_t1, h_t2});
      check(sb.size() == 0, "R9 no result without strobe", sb.size(), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule